// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from up to sixteen internal sources into a sticky status vector and drives one interrupt line toward a host processor. Each source has a fixed bit position. A host-side mask decides which status bits may raise the line. Status bits always record events, whatever the mask holds, so the host can poll masked sources.

The host reaches the block through a small register bus with address, write enable, write data, read enable and registered read data. The host can write the mask directly or change it one bit at a time through separate set and clear ports, with no read-modify-write. Status can be read in two ways: one read leaves it intact and the other clears it. A write-one-to-acknowledge port clears chosen bits. Two configuration inputs enable the line and select its polarity.

Register addresses: 0 mask (read/write), 1 mask-set (write only), 2 mask-clear (write only), 3 status peek (read only, no side effect), 4 status read-and-clear (read only), 5 acknowledge (write only). Source bits: 0 receive buffer 0, 1 transmit data, 2 transmit transfer, 3 receive buffer 1, 4 receive transfer, 5 and 6 event mailbox, 7 wake, 8 and 9 trace, 10 command complete, 14 init complete. Bits 11, 12, 13 and 15 are not implemented.

Top module: `hint_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001 (only bit 0 masked), status reads 0x0000, and the interrupt line is at its inactive level.
- R2: A write to address 1 sets every mask bit written as 1. Mask bits written as 0 keep their value.
- R3: A write to address 2 clears every mask bit written as 1. Mask bits written as 0 keep their value.
- R4: A write to address 0 replaces the whole mask, and a read of address 0 returns it.
- R5: An event pulse on an implemented source sets its status bit whatever the mask holds. Bits 11, 12, 13 and 15 always read 0.
- R6: A read of address 3 returns the status and leaves it unchanged.
- R7: A read of address 4 returns the status and clears every status bit afterwards.
- R8: A write to address 5 clears each status bit written as 1, as seen by both status views. Bits written as 0 have no effect.
- R9: An event on a bit in the same cycle as a read-and-clear or acknowledge of that bit leaves the bit set.
- R10: With the enable input at 1, the line is asserted one cycle after some status bit is set while its mask bit is 0, and it is deasserted one cycle after no such bit remains. With the enable input at 0 the line is deasserted.
- R11: With the active-low select at 0 the asserted level is 1. With it at 1 the asserted level is 0 and the inactive level is 1.
- R12: Read data is valid in the cycle after read enable. Reads of write-only or unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | Event pulses, one per source |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | NSRC | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | NSRC | Read data, registered |
| cfg_int_en | input | 1 | Interrupt line enable |
| cfg_act_low | input | 1 | Selects active-low polarity |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The checker checks on every cycle that the mask-set and mask-clear ports touch only the bits written as 1, and that events always latch. It also checks that a read-and-clear leaves only the events of the same cycle, that an acknowledge clears its bits unless an event arrives at the same time, and that the line follows the masked status one cycle later. Only the bench scenarios can show the reset values, that write-only and unmapped addresses read as zero, that a peek read changes nothing over time, and how the line behaves when the polarity and enable inputs change while the status stays fixed.

// File: rtl/hint_pkg.sv
package hint_pkg;
   typedef enum logic [2:0] {
      RA_MASK  = 3'd0,
      RA_MSET  = 3'd1,
      RA_MCLR  = 3'd2,
      RA_PEEK  = 3'd3,
      RA_RDCLR = 3'd4,
      RA_ACK   = 3'd5
   } reg_addr_e;

   localparam int SRC_RXBUF0  = 0;
   localparam int SRC_TXDATA  = 1;
   localparam int SRC_TXXFER  = 2;
   localparam int SRC_RXBUF1  = 3;
   localparam int SRC_RXXFER  = 4;
   localparam int SRC_MBOX_A  = 5;
   localparam int SRC_MBOX_B  = 6;
   localparam int SRC_WAKE    = 7;
   localparam int SRC_TRACE_A = 8;
   localparam int SRC_TRACE_B = 9;
   localparam int SRC_CMDDONE = 10;
   localparam int SRC_INITDONE = 14;

   localparam logic [15:0] SRC_USED_DEFAULT = 16'h47FF;
   localparam logic [15:0] MASK_RST_DEFAULT = 16'h0001;

   typedef struct packed {
      logic mask_wr;
      logic mask_set;
      logic mask_clr;
      logic ack_wr;
      logic peek_rd;
      logic rdclr_rd;
   } strobe_t;
endpackage

// File: rtl/hint_regdec.sv
module hint_regdec
   import hint_pkg::*;
#(
   parameter int ADDR_W = 3
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output strobe_t           strb
);
   localparam int AW_MIN = 3;

   initial begin
      if (ADDR_W < AW_MIN) $error("hint_regdec: ADDR_W must be at least %0d", AW_MIN);
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
      return a == ADDR_W'(r);
   endfunction

   always_comb begin
      strb.mask_wr  = we && hit(addr, RA_MASK);
      strb.mask_set = we && hit(addr, RA_MSET);
      strb.mask_clr = we && hit(addr, RA_MCLR);
      strb.ack_wr   = we && hit(addr, RA_ACK);
      strb.peek_rd  = re && hit(addr, RA_PEEK);
      strb.rdclr_rd = re && hit(addr, RA_RDCLR);
   end
endmodule

// File: rtl/hint_mask.sv
module hint_mask
   import hint_pkg::*;
#(
   parameter int              NSRC     = 16,
   parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  strobe_t         strb,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] mask_q
);
   logic [NSRC-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (strb.mask_wr)  mask_d = wdata;
      if (strb.mask_set) mask_d = mask_q | wdata;
      if (strb.mask_clr) mask_d = mask_q & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= MASK_RST;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/hint_status.sv
module hint_status #(
   parameter int              NSRC     = 16,
   parameter logic [NSRC-1:0] SRC_USED = '1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] stat_q
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      if (SRC_USED[i]) begin : g_cell
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (evt[i]) bit_q <= 1'b1;
            else if (clr[i]) bit_q <= 1'b0;
         end
         assign stat_q[i] = bit_q;
      end else begin : g_none
         assign stat_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/hint_irq_out.sv
module hint_irq_out #(
   parameter int NSRC = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] stat,
   input  logic [NSRC-1:0] mask,
   input  logic            en,
   input  logic            act_low,
   output logic            irq
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= en && |(stat & ~mask);
   end

   assign irq = pend_q ^ act_low;
endmodule

// File: rtl/hint_ctrl.sv
module hint_ctrl
   import hint_pkg::*;
#(
   parameter int              NSRC     = 16,
   parameter int              ADDR_W   = 3,
   parameter logic [NSRC-1:0] SRC_USED = NSRC'(SRC_USED_DEFAULT),
   parameter logic [NSRC-1:0] MASK_RST = NSRC'(MASK_RST_DEFAULT)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NSRC-1:0]   bus_wdata,
   input  logic              bus_re,
   output logic [NSRC-1:0]   bus_rdata,
   input  logic              cfg_int_en,
   input  logic              cfg_act_low,
   output logic              host_irq
);
   localparam int NSRC_MAX = 32;

   initial begin
      if (NSRC < 1 || NSRC > NSRC_MAX) $error("hint_ctrl: NSRC out of range");
      if (SRC_USED == '0) $error("hint_ctrl: no source implemented");
   end

   strobe_t         strb;
   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] clr_vec;
   logic [NSRC-1:0] rdata_q;

   hint_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .we(bus_we), .re(bus_re), .strb(strb)
   );

   hint_mask #(.NSRC(NSRC), .MASK_RST(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(bus_wdata), .mask_q(mask_q)
   );

   always_comb begin
      clr_vec = '0;
      if (strb.ack_wr)   clr_vec = bus_wdata;
      if (strb.rdclr_rd) clr_vec = clr_vec | '1;
   end

   hint_status #(.NSRC(NSRC), .SRC_USED(SRC_USED)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr_vec), .stat_q(stat_q)
   );

   hint_irq_out #(.NSRC(NSRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat(stat_q), .mask(mask_q),
      .en(cfg_int_en), .act_low(cfg_act_low), .irq(host_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (bus_re) begin
         if (bus_addr == ADDR_W'(RA_MASK))               rdata_q <= mask_q;
         else if (strb.peek_rd || strb.rdclr_rd)         rdata_q <= stat_q;
         else                                            rdata_q <= '0;
      end
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/hint_ctrl_chk.sv
module hint_ctrl_chk
   import hint_pkg::*;
#(
   parameter int              NSRC     = 16,
   parameter int              ADDR_W   = 3,
   parameter logic [NSRC-1:0] SRC_USED = '1
)(
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   evt_i,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [NSRC-1:0]   bus_wdata,
   input logic              bus_re,
   input logic              cfg_int_en,
   input logic              cfg_act_low,
   input logic              host_irq,
   input logic [NSRC-1:0]   stat,
   input logic [NSRC-1:0]   mask
);
   logic wr_set, wr_clr, wr_ack, rd_clr;
   assign wr_set = bus_we && bus_addr == ADDR_W'(RA_MSET);
   assign wr_clr = bus_we && bus_addr == ADDR_W'(RA_MCLR);
   assign wr_ack = bus_we && bus_addr == ADDR_W'(RA_ACK);
   assign rd_clr = bus_re && bus_addr == ADDR_W'(RA_RDCLR);

   assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (mask & $past(bus_wdata)) == $past(bus_wdata));

   assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (mask & $past(bus_wdata)) == '0);

   assert_evt_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      |(evt_i & SRC_USED) |=> (stat & $past(evt_i & SRC_USED)) == $past(evt_i & SRC_USED));

   assert_rdclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> stat == $past(evt_i & SRC_USED));

   assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> (stat & $past(bus_wdata & ~evt_i)) == '0);

   assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (host_irq ^ cfg_act_low) == $past(cfg_int_en && |(stat & ~mask)));
endmodule

bind hint_ctrl hint_ctrl_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .SRC_USED(SRC_USED)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_re(bus_re), .cfg_int_en(cfg_int_en),
   .cfg_act_low(cfg_act_low), .host_irq(host_irq), .stat(stat_q), .mask(mask_q)
);

// File: tb/sim_hint_ctrl.sv
`timescale 1ns/1ps
module sim_hint_ctrl;
   localparam int NSRC = 16;
   localparam int AW   = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] evt_i = '0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [NSRC-1:0] bus_wdata = '0;
   logic            bus_re = 1'b0;
   logic [NSRC-1:0] bus_rdata;
   logic            cfg_int_en = 1'b1;
   logic            cfg_act_low = 1'b0;
   logic            host_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hint_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .cfg_int_en(cfg_int_en), .cfg_act_low(cfg_act_low), .host_irq(host_irq)
   );

   logic [NSRC-1:0] exp_q[$];
   string           tag_q[$];
   logic            re_seen = 1'b0;

   always @(posedge clk) re_seen <= bus_re;

   always @(negedge clk) begin
      if (re_seen) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R12: unexpected read data %h, expected none", bus_rdata);
         end else begin
            logic [NSRC-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL %s: read data %h, expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [NSRC-1:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [NSRC-1:0] e, input string t);
      bus_addr = a; bus_re = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic pulse(input logic [NSRC-1:0] b);
      evt_i = b;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_cmp++;
      if (host_irq !== e) begin
         n_bad++;
         $display("FAIL %s: host_irq %b, expected %b", t, host_irq, e);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk_irq(1'b0, "R1");
      rd(3'd0, 16'h0001, "R1");
      rd(3'd3, 16'h0000, "R1");
      // R5: masked source still latches; R10 line stays low
      pulse(16'h0001);
      @(negedge clk);
      chk_irq(1'b0, "R10");
      rd(3'd3, 16'h0001, "R5");
      // R2 mask set
      wr(3'd1, 16'h0010);
      rd(3'd0, 16'h0011, "R2");
      // R3 mask clear -> bit 0 unmasked, line rises
      wr(3'd2, 16'h0001);
      rd(3'd0, 16'h0010, "R3");
      chk_irq(1'b1, "R10");
      // R5 unimplemented bits read zero
      pulse(16'hFFFF);
      rd(3'd3, 16'h47FF, "R5");
      rd(3'd3, 16'h47FF, "R6");
      // R8 ack
      wr(3'd5, 16'h0401);
      rd(3'd3, 16'h43FE, "R8");
      // R7 read and clear
      rd(3'd4, 16'h43FE, "R7");
      rd(3'd3, 16'h0000, "R7");
      chk_irq(1'b0, "R10");
      // R9 event wins over ack
      pulse(16'h0002);
      evt_i = 16'h0002;
      wr(3'd5, 16'h0002);
      evt_i = '0;
      rd(3'd3, 16'h0002, "R9");
      // R9 event wins over read-and-clear
      evt_i = 16'h0004;
      rd(3'd4, 16'h0002, "R9");
      evt_i = '0;
      rd(3'd3, 16'h0004, "R9");
      // R8 writing zero has no effect
      wr(3'd5, 16'h0000);
      rd(3'd3, 16'h0004, "R8");
      // R4 direct mask write; everything masked
      wr(3'd0, 16'hFFFF);
      rd(3'd0, 16'hFFFF, "R4");
      chk_irq(1'b0, "R10");
      wr(3'd0, 16'h0000);
      @(negedge clk);
      chk_irq(1'b1, "R10");
      // R11 polarity
      cfg_act_low = 1'b1;
      #1;
      chk_irq(1'b0, "R11");
      cfg_int_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk_irq(1'b1, "R11");
      cfg_act_low = 1'b0;
      #1;
      chk_irq(1'b0, "R10");
      cfg_int_en = 1'b1;
      // R12 write-only and unmapped addresses
      rd(3'd1, 16'h0000, "R12");
      rd(3'd5, 16'h0000, "R12");
      rd(3'd7, 16'h0000, "R12");
      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule